// File: doc/BRIEF.md
# Display Serial Link Read-Back Response Decoder

This block sits behind the receive word queue of a display serial link host. After the host hands the bus to the panel and the panel answers, the queue holds a group of 32-bit words. The block is started by the host CPU together with the largest number of bytes the caller can accept. It then consumes the whole group from the queue and presents one classified result.

The first word of the group is a trigger code, which tells an acknowledge from an escape. The second word is a packet header. Its low six bits name the data type, and that type selects how the rest is read:
- an error report, which yields a 16-bit error bitmap;
- a one- or two-byte short read reply, whose bytes sit in the header;
- a long read reply, whose declared length sits in the header and whose payload follows in later words.

Payload words are unpacked least significant byte first. The reported byte count is limited to the caller's maximum, and unknown data types raise a protocol error. The result is held on a valid/ready handshake until the CPU takes it.

Top module: `dsirx_resp_decoder`

## Requirements
- R1: After reset `res_valid` is 0 and no word is popped until a start is accepted.
- R2: `start` is taken only while the block is idle; the block latches `req_len` with it. A start pulsed while a response is in progress or a result is pending has no effect.
- R3: After a start, the block waits until `rxq_level` is non-zero. It then notes that level as the group size N and pops the trigger word. Trigger code 0x84 gives `res_trig`=0, 0x87 gives 1, and any other value gives 2. When N is 1 the result is class 0 with zero bytes.
- R4: The header data type is bits 5:0 of the header word. Type 0x02 gives class 1, a byte count of 0, and `res_errmap` = header bits 23:8. In that bitmap, bit 0 is start-of-transmission error, bit 7 is contention, bits 8/9 are single/multi-bit ECC errors, bit 10 is checksum error, bit 14 is reserved and bit 15 is protocol violation. For every other class `res_errmap` is 0.
- R5: Type 0x21 gives class 2 with byte 0 = header bits 15:8 and a nominal size of 1. Type 0x22 gives class 2 with byte 0 = bits 15:8, byte 1 = bits 23:16 and a nominal size of 2.
- R6: Types 0x1C and 0x1A give class 3. The nominal size is header bits 23:8, with bits 15:8 as its low byte.
- R7: For class 3, payload word w (counting from 0 after the header) supplies bytes 4w to 4w+3, taken from its bit lanes 7:0, 15:8, 23:16 and 31:24. Only byte indices below the limit L are stored. Every byte not written is 0.
- R8: Any other data type gives class 4 with `res_proto_err`=1, a byte count of 0 and all bytes 0.
- R9: Exactly N words are popped for every response, whatever its class. No pop happens while `rxq_level` is 0.
- R10: One result is produced per response. While `res_valid` is high and `res_ready` is low, every result field holds steady and nothing is popped. A cycle with both high returns the block to idle.
- R11: The limit L is min(`req_len`, MAX_BYTES), and `res_count` is min(nominal size, L).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin decoding one response (taken only when idle) |
| req_len | input | REQ_W | Largest byte count the caller accepts |
| rxq_level | input | LVL_W | Receive queue occupancy in words |
| rxq_data | input | 32 | Word at the head of the receive queue |
| rxq_pop | output | 1 | Consume the head word this cycle |
| res_valid | output | 1 | Result is available |
| res_ready | input | 1 | Host takes the result |
| res_class | output | 3 | 0 trigger only, 1 error report, 2 short read, 3 long read, 4 bad type |
| res_trig | output | 2 | 0 acknowledge, 1 escape, 2 unknown |
| res_bytes | output | 8*MAX_BYTES | Extracted bytes, byte i at bits 8i+7:8i |
| res_count | output | LEN_W | Reported byte count |
| res_errmap | output | 16 | Error bitmap from an error report |
| res_proto_err | output | 1 | Data type not recognised |

## Verification
The hardest situations to reach from the ports are those where the caller's limit cuts a long reply in the middle of a payload word, and those where the limit exceeds the internal byte store. In both, only part of a popped word may land. The stimulus aims at these by choosing declared lengths, requested lengths and word counts so that the cut falls inside a word and beyond MAX_BYTES. Start pulses are also placed while the block waits on an empty queue and while a result is pending, so a stray start can be seen to leave both the limit and the queue untouched.

// File: rtl/dsirx_pkg.sv
package dsirx_pkg;

   typedef enum logic [2:0] {
      RC_TRIG_ONLY = 3'd0,
      RC_ACK_ERR   = 3'd1,
      RC_SHORT     = 3'd2,
      RC_LONG      = 3'd3,
      RC_BAD       = 3'd4
   } rsp_class_e;

   typedef enum logic [1:0] {
      TG_ACK = 2'd0,
      TG_ESC = 2'd1,
      TG_UNK = 2'd2
   } trig_e;

   localparam logic [5:0] DT_ACK_ERR  = 6'h02;
   localparam logic [5:0] DT_SHORT1   = 6'h21;
   localparam logic [5:0] DT_SHORT2   = 6'h22;
   localparam logic [5:0] DT_DCS_LONG = 6'h1C;
   localparam logic [5:0] DT_GEN_LONG = 6'h1A;

   localparam logic [31:0] TRIG_ACK_CODE = 32'h0000_0084;
   localparam logic [31:0] TRIG_ESC_CODE = 32'h0000_0087;

   typedef struct packed {
      rsp_class_e  cls;
      logic [15:0] errmap;
      logic [15:0] size;
      logic        perr;
   } hdr_info_t;

endpackage

// File: rtl/dsirx_trig_class.sv
module dsirx_trig_class
   import dsirx_pkg::*;
(
   input  logic [31:0] word,
   output trig_e       trig
);

   always_comb begin
      if (word == TRIG_ACK_CODE)      trig = TG_ACK;
      else if (word == TRIG_ESC_CODE) trig = TG_ESC;
      else                            trig = TG_UNK;
   end

endmodule

// File: rtl/dsirx_hdr_decode.sv
module dsirx_hdr_decode
   import dsirx_pkg::*;
(
   input  logic [5:0]  dtype,
   input  logic [15:0] field,
   output hdr_info_t   info
);

   always_comb begin
      info.cls    = RC_BAD;
      info.errmap = 16'h0000;
      info.size   = 16'd0;
      info.perr   = 1'b0;
      unique case (dtype)
         DT_ACK_ERR: begin
            info.cls    = RC_ACK_ERR;
            info.errmap = field;
         end
         DT_SHORT1: begin
            info.cls  = RC_SHORT;
            info.size = 16'd1;
         end
         DT_SHORT2: begin
            info.cls  = RC_SHORT;
            info.size = 16'd2;
         end
         DT_DCS_LONG, DT_GEN_LONG: begin
            info.cls  = RC_LONG;
            info.size = field;
         end
         default: begin
            info.cls  = RC_BAD;
            info.perr = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/dsirx_byte_store.sv
module dsirx_byte_store #(
   parameter int MAX_BYTES = 16,
   parameter int LEN_W     = 5,
   parameter int WI_W      = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   sh_we,
   input  logic                   sh_two,
   input  logic [7:0]             sh_b0,
   input  logic [7:0]             sh_b1,
   input  logic                   wd_we,
   input  logic [WI_W-1:0]        wd_idx,
   input  logic [31:0]            wd_data,
   input  logic [LEN_W-1:0]       lim,
   output logic [8*MAX_BYTES-1:0] bytes
);

   for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
      localparam int              LANE = b % 4;
      localparam logic [WI_W-1:0] WSEL = WI_W'(b / 4);
      localparam logic [LEN_W-1:0] POS = LEN_W'(b);

      logic       in_lim;
      logic       sh_hit;
      logic [7:0] sh_val;
      logic [7:0] r;

      assign in_lim = POS < lim;

      if (b == 0) begin : g_s0
         assign sh_hit = sh_we;
         assign sh_val = sh_b0;
      end else if (b == 1) begin : g_s1
         assign sh_hit = sh_we && sh_two;
         assign sh_val = sh_b1;
      end else begin : g_sn
         assign sh_hit = 1'b0;
         assign sh_val = 8'h00;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  r <= 8'h00;
         else if (clear)                              r <= 8'h00;
         else if (wd_we && (wd_idx == WSEL) && in_lim) r <= wd_data[LANE*8 +: 8];
         else if (sh_hit && in_lim)                   r <= sh_val;
      end

      assign bytes[8*b +: 8] = r;
   end

endmodule

// File: rtl/dsirx_resp_decoder.sv
module dsirx_resp_decoder
   import dsirx_pkg::*;
#(
   parameter int MAX_BYTES = 16,
   parameter int LVL_W     = 5,
   parameter int REQ_W     = 16,
   parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [REQ_W-1:0]       req_len,
   input  logic [LVL_W-1:0]       rxq_level,
   input  logic [31:0]            rxq_data,
   output logic                   rxq_pop,
   output logic                   res_valid,
   input  logic                   res_ready,
   output logic [2:0]             res_class,
   output logic [1:0]             res_trig,
   output logic [8*MAX_BYTES-1:0] res_bytes,
   output logic [LEN_W-1:0]       res_count,
   output logic [15:0]            res_errmap,
   output logic                   res_proto_err
);

   localparam logic [REQ_W-1:0] REQ_CAP = REQ_W'(MAX_BYTES);
   localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_BYTES);

   if (MAX_BYTES < 2 || MAX_BYTES > 64) begin : g_bad_bytes
      $error("MAX_BYTES must lie in 2..64");
   end
   if (LVL_W < 2 || LVL_W > 8) begin : g_bad_lvl
      $error("LVL_W must lie in 2..8");
   end
   if (REQ_W < LEN_W || LEN_W > 16) begin : g_bad_req
      $error("REQ_W must cover LEN_W and LEN_W must not exceed 16");
   end

   typedef enum logic [2:0] {S_IDLE, S_WAIT, S_HDR, S_BODY, S_DONE} st_e;

   st_e               st;
   logic [LEN_W-1:0]  lim_q;
   logic [LVL_W-1:0]  left_q;
   logic [LVL_W-1:0]  widx_q;
   trig_e             trig_q;
   rsp_class_e        cls_q;
   logic [15:0]       errmap_q;
   logic              perr_q;
   logic [LEN_W-1:0]  count_q;

   trig_e             trig_w;
   hdr_info_t         info_w;
   logic              reading;
   logic              take;
   logic [LEN_W-1:0]  lim_d;
   logic [LEN_W-1:0]  clamp_w;

   dsirx_trig_class u_trig (
      .word (rxq_data),
      .trig (trig_w)
   );

   dsirx_hdr_decode u_hdr (
      .dtype (rxq_data[5:0]),
      .field (rxq_data[23:8]),
      .info  (info_w)
   );

   assign reading = (st == S_WAIT) || (st == S_HDR) || (st == S_BODY);
   assign rxq_pop = reading && (rxq_level != '0);
   assign take    = (st == S_IDLE) && start;
   assign lim_d   = (req_len > REQ_CAP) ? LEN_CAP : req_len[LEN_W-1:0];
   assign clamp_w = (info_w.size > 16'(lim_q)) ? lim_q : info_w.size[LEN_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         lim_q    <= '0;
         left_q   <= '0;
         widx_q   <= '0;
         trig_q   <= TG_ACK;
         cls_q    <= RC_TRIG_ONLY;
         errmap_q <= 16'h0000;
         perr_q   <= 1'b0;
         count_q  <= '0;
      end else begin
         unique case (st)
            S_IDLE: if (start) begin
               st       <= S_WAIT;
               lim_q    <= lim_d;
               widx_q   <= '0;
               trig_q   <= TG_ACK;
               cls_q    <= RC_TRIG_ONLY;
               errmap_q <= 16'h0000;
               perr_q   <= 1'b0;
               count_q  <= '0;
            end
            S_WAIT: if (rxq_pop) begin
               trig_q <= trig_w;
               left_q <= rxq_level - 1'b1;
               st     <= (rxq_level == LVL_W'(1)) ? S_DONE : S_HDR;
            end
            S_HDR: if (rxq_pop) begin
               cls_q    <= info_w.cls;
               errmap_q <= info_w.errmap;
               perr_q   <= info_w.perr;
               count_q  <= clamp_w;
               left_q   <= left_q - 1'b1;
               st       <= (left_q == LVL_W'(1)) ? S_DONE : S_BODY;
            end
            S_BODY: if (rxq_pop) begin
               widx_q <= widx_q + 1'b1;
               left_q <= left_q - 1'b1;
               if (left_q == LVL_W'(1)) st <= S_DONE;
            end
            S_DONE: if (res_ready) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   dsirx_byte_store #(
      .MAX_BYTES (MAX_BYTES),
      .LEN_W     (LEN_W),
      .WI_W      (LVL_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (take),
      .sh_we   ((st == S_HDR) && rxq_pop && (info_w.cls == RC_SHORT)),
      .sh_two  (info_w.size[1]),
      .sh_b0   (rxq_data[15:8]),
      .sh_b1   (rxq_data[23:16]),
      .wd_we   ((st == S_BODY) && rxq_pop && (cls_q == RC_LONG)),
      .wd_idx  (widx_q),
      .wd_data (rxq_data),
      .lim     (lim_q),
      .bytes   (res_bytes)
   );

   assign res_valid     = (st == S_DONE);
   assign res_class     = cls_q;
   assign res_trig      = trig_q;
   assign res_count     = count_q;
   assign res_errmap    = errmap_q;
   assign res_proto_err = perr_q;

endmodule

// File: rtl/dsirx_resp_chk.sv
module dsirx_resp_chk #(
   parameter int MAX_BYTES = 16,
   parameter int LVL_W     = 5,
   parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [LVL_W-1:0]       rxq_level,
   input logic                   rxq_pop,
   input logic                   res_valid,
   input logic                   res_ready,
   input logic [2:0]             res_class,
   input logic [8*MAX_BYTES-1:0] res_bytes,
   input logic [LEN_W-1:0]       res_count,
   input logic [15:0]            res_errmap,
   input logic                   res_proto_err
);

   // R9: a pop is never issued against an empty queue
   a_r9_pop_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
      rxq_pop |-> (rxq_level != '0));

   // R10: a pending result holds steady
   a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |=> (res_valid && $stable(res_class) && $stable(res_count)
                                     && $stable(res_bytes) && $stable(res_errmap)
                                     && $stable(res_proto_err)));

   // R10: nothing is consumed while a result waits
   a_r10_no_pop_pending: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !rxq_pop);

   // R8: an unknown type carries no data
   a_r8_bad_type_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_class == 3'd4) |-> (res_proto_err && res_count == '0 && res_bytes == '0));

   // R4: the bitmap is only non-zero for an error report
   a_r4_errmap_only_report: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_class != 3'd1) |-> (res_errmap == 16'h0000));

   // R5: a short reply never reports more than two bytes
   a_r5_short_count: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_class == 3'd2) |-> (res_count <= LEN_W'(2)));

   // R11: the count never exceeds the store
   a_r11_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_count <= LEN_W'(MAX_BYTES)));

   // R3: a trigger-only group reports zero bytes
   a_r3_trig_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_class == 3'd0) |-> (res_count == '0 && res_bytes == '0));

endmodule

bind dsirx_resp_decoder dsirx_resp_chk #(
   .MAX_BYTES (MAX_BYTES),
   .LVL_W     (LVL_W),
   .LEN_W     (LEN_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rxq_level     (rxq_level),
   .rxq_pop       (rxq_pop),
   .res_valid     (res_valid),
   .res_ready     (res_ready),
   .res_class     (res_class),
   .res_bytes     (res_bytes),
   .res_count     (res_count),
   .res_errmap    (res_errmap),
   .res_proto_err (res_proto_err)
);

// File: tb/sim_dsirx_resp_decoder.sv
`timescale 1ns/1ps
module sim_dsirx_resp_decoder;

   localparam int MB   = 16;
   localparam int LVLW = 5;
   localparam int REQW = 16;
   localparam int LENW = $clog2(MB + 1);
   localparam real PER = 8.0;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [REQW-1:0]   req_len = '0;
   logic [LVLW-1:0]   rxq_level = '0;
   logic [31:0]       rxq_data = '0;
   logic              rxq_pop;
   logic              res_valid;
   logic              res_ready = 1'b0;
   logic [2:0]        res_class;
   logic [1:0]        res_trig;
   logic [8*MB-1:0]   res_bytes;
   logic [LENW-1:0]   res_count;
   logic [15:0]       res_errmap;
   logic              res_proto_err;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [31:0] q[$];
   logic [31:0] cur[$];
   bit popflag = 0;

   // expected result
   int          e_cls, e_trig, e_cnt, e_perr;
   logic [15:0] e_em;
   logic [8*MB-1:0] e_bytes;

   always #(PER/2) clk = ~clk;

   dsirx_resp_decoder #(.MAX_BYTES(MB), .LVL_W(LVLW), .REQ_W(REQW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .req_len(req_len),
      .rxq_level(rxq_level), .rxq_data(rxq_data), .rxq_pop(rxq_pop),
      .res_valid(res_valid), .res_ready(res_ready), .res_class(res_class),
      .res_trig(res_trig), .res_bytes(res_bytes), .res_count(res_count),
      .res_errmap(res_errmap), .res_proto_err(res_proto_err)
   );

   task automatic refresh();
      rxq_level = (q.size() > 31) ? LVLW'(31) : LVLW'(q.size());
      rxq_data  = (q.size() > 0) ? q[0] : 32'h0;
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [8*MB-1:0] act, input logic [8*MB-1:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // queue model: sample the pop request just before each rising edge
   always begin
      @(negedge clk);
      #(PER/2 - 1.0);
      popflag = rxq_pop;
      if (rst_n) chk(!(rxq_pop && rxq_level == 0), "R9", "pop on empty", 0, 0);
   end
   always @(posedge clk) begin
      #1;
      if (popflag && q.size() > 0) begin
         void'(q.pop_front());
         refresh();
      end
   end

   // behavioural reference for one response group
   task automatic model(input int req);
      int lim, n, sz;
      logic [31:0] h;
      lim = (req > MB) ? MB : req;
      n = cur.size();
      e_cls = 0; e_cnt = 0; e_perr = 0; e_em = 0; e_bytes = '0; sz = 0;
      e_trig = (cur[0] == 32'h84) ? 0 : (cur[0] == 32'h87) ? 1 : 2;
      if (n > 1) begin
         h = cur[1];
         case (h[5:0])
            6'h02: begin e_cls = 1; e_em = h[23:8]; end
            6'h21: begin e_cls = 2; sz = 1; if (lim > 0) e_bytes[7:0] = h[15:8]; end
            6'h22: begin
               e_cls = 2; sz = 2;
               if (lim > 0) e_bytes[7:0]  = h[15:8];
               if (lim > 1) e_bytes[15:8] = h[23:16];
            end
            6'h1C, 6'h1A: begin
               e_cls = 3; sz = int'(h[23:8]);
               for (int i = 2; i < n; i++)
                  for (int k = 0; k < 4; k++) begin
                     int idx;
                     idx = (i - 2) * 4 + k;
                     if (idx < lim) e_bytes[idx*8 +: 8] = cur[i][8*k +: 8];
                  end
            end
            default: begin e_cls = 4; e_perr = 1; end
         endcase
      end
      e_cnt = (sz < lim) ? sz : lim;
   endtask

   task automatic pulse_start(input int req);
      @(negedge clk);
      start = 1'b1; req_len = REQW'(req);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic push_cur();
      foreach (cur[i]) q.push_back(cur[i]);
      refresh();
   endtask

   task automatic wait_valid(input string req);
      int t;
      t = 0;
      while (!res_valid && t < 300) begin @(negedge clk); t++; end
      chk(res_valid, req, "result valid", {127'b0, res_valid}, 1);
   endtask

   task automatic compare(input string req);
      chk(res_class == 3'(e_cls), req, "class", res_class, e_cls);
      chk(res_trig == 2'(e_trig), req, "trigger", res_trig, e_trig);
      chk(res_count == LENW'(e_cnt), req, "count", res_count, e_cnt);
      chk(res_bytes == e_bytes, req, "bytes", res_bytes, e_bytes);
      chk(res_errmap == e_em, req, "errmap", res_errmap, e_em);
      chk(res_proto_err == 1'(e_perr), req, "proto err", res_proto_err, e_perr);
   endtask

   task automatic release_result();
      // R10: hold steady for two cycles with ready low
      @(negedge clk);
      @(negedge clk);
      chk(res_valid, "R10", "held valid", res_valid, 1);
      compare("R10");
      res_ready = 1'b1;
      @(negedge clk);
      res_ready = 1'b0;
      chk(!res_valid, "R10", "valid drops", res_valid, 0);
      chk(q.size() == 0, "R9", "all words popped", q.size(), 0);
   endtask

   task automatic run(input int req, input string tag);
      model(req);
      pulse_start(req);
      push_cur();
      wait_valid(tag);
      compare(tag);
      release_result();
   endtask

   initial begin
      #(PER * 200000);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      refresh();
      repeat (3) @(negedge clk);
      chk(!res_valid, "R1", "valid in reset", res_valid, 0);
      rst_n = 1'b1;
      // R1/R2: words present but no start: nothing popped
      q.push_back(32'h84); refresh();
      repeat (4) @(negedge clk);
      chk(q.size() == 1 && !res_valid, "R1", "no pop before start", q.size(), 1);
      q.delete(); refresh();

      // R4: error report, ack trigger, bits 0,7,8,10,15
      cur = '{32'h84, 32'h0085_8102};
      run(4, "R4");

      // R3: escape trigger alone
      cur = '{32'h87};
      run(4, "R3");

      // R3/R5: unknown trigger, one-byte short reply
      cur = '{32'h55, 32'h0000_A521};
      run(4, "R5");

      // R5/R11: two-byte short reply cut to one byte
      cur = '{32'h84, 32'h00C3_B222};
      run(1, "R11");

      // R5: two-byte short reply in full
      cur = '{32'h84, 32'h0077_6622};
      run(8, "R5");

      // R6/R7: long reply, declared 6, two payload words
      cur = '{32'h84, 32'h0000_061C, 32'h4433_2211, 32'h8877_6655};
      run(16, "R7");

      // R6/R7/R11: generic long, limit cuts inside second word
      cur = '{32'h84, 32'h0000_0A1A, 32'hDDCC_BBAA, 32'h1100_FFEE, 32'h5544_3322};
      run(5, "R7");

      // R6: length low byte and high byte in the header
      cur = '{32'h84, 32'h0001_021C, 32'h0403_0201};
      run(3, "R6");

      // R11: request beyond the store, five payload words
      cur = '{32'h84, 32'h0000_141C, 32'h0302_0100, 32'h0706_0504,
              32'h0B0A_0908, 32'h0F0E_0D0C, 32'h1312_1110};
      run(40, "R11");

      // R8: unrecognised data type with a trailing word
      cur = '{32'h84, 32'h00FF_EE15, 32'hCAFE_F00D};
      run(16, "R8");

      // R2/R3: start while waiting on an empty queue is ignored
      cur = '{32'h84, 32'h0000_081C, 32'h6655_4433, 32'hAA99_8877};
      model(2);
      pulse_start(2);
      repeat (4) @(negedge clk);
      chk(!res_valid, "R3", "waits on empty queue", res_valid, 0);
      pulse_start(16);
      push_cur();
      wait_valid("R2");
      compare("R2");
      // start during a pending result is ignored
      @(negedge clk);
      start = 1'b1; req_len = 16'd9;
      @(negedge clk);
      start = 1'b0;
      compare("R2");
      res_ready = 1'b1;
      @(negedge clk);
      res_ready = 1'b0;
      q.push_back(32'h84); refresh();
      repeat (4) @(negedge clk);
      chk(q.size() == 1 && !res_valid, "R2", "start while pending", q.size(), 1);
      q.delete(); refresh();

      // R10: back-to-back responses, one result each
      cur = '{32'h87, 32'h0000_1221};
      run(2, "R10");

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule